// File: doc/BRIEF.md
# Multi-Event-Buffer Busy Generator

This block tells the central trigger source to stop sending triggers when the front-end event buffers cannot take another event. It counts the triggers it accepts, registers the event count that each readout receiver reports, and works out how far the accepted count is ahead of each receiver. The receiver that is furthest behind decides the busy state. Busy rises when that gap reaches the selected buffer depth (4 or 8 events). Since the trigger source stops while busy is high, busy falls only when the slowest receiver catches up.

An optional mask path blocks triggers locally. When masking is enabled, a trigger is dropped and not counted if the buffers report full, if the data link is not ready, or if 8 events are already outstanding. Each receiver can be left out of the slowest-receiver choice through its own enable bit. An event-count reset sets the trigger count and all tracked receiver counts back to zero in the same cycle.

Top module: `meb_busy_gen`

## Requirements
- R1: A trigger strobe that is not masked and not overridden by an event-count reset adds one to the accepted count. The count is 12 bits wide, wraps from 4095 to 0, and appears on `trig_cnt_o` after the next rising clock edge.
- R2: The lag of a receiver is (accepted count minus its registered reported count) modulo 4096. The slowest receiver is the enabled receiver with the largest lag. A reported count is registered on each clock edge.
- R3: `busy_o` is a register. After each edge it is high exactly when, in the cycle before, some receiver was enabled and the largest enabled lag was at least the depth: 4 when `depth8_i` = 0, and 8 when `depth8_i` = 1.
- R4: Once the slowest receiver's lag falls below the depth, `busy_o` goes low one edge later.
- R5: A receiver whose bit in `rx_enable_i` is 0 has no effect on the lag choice. When no receiver is enabled, `busy_o` goes low after the next edge.
- R6: When `mask_en_i` = 1 and either `buf_full_i` = 1 or `link_rdy_i` = 0, `trig_mask_o` is high in that same cycle, and a trigger presented in that cycle leaves the accepted count unchanged.
- R7: When `mask_en_i` = 1 and the largest enabled lag is 8 or more, `trig_mask_o` is high and triggers are dropped. This keeps at most 8 events outstanding.
- R8: When `mask_en_i` = 0, `trig_mask_o` is low and every trigger is counted, whatever the full, link or lag state.
- R9: `evt_rst_i` = 1 sets the accepted count and every tracked receiver count to zero on the next edge. It wins over a trigger in the same cycle.
- R10: While `rst_n` is low, and on the first edge after it goes high, `trig_cnt_o` = 0 and `busy_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | One-cycle trigger strobe from the decoder |
| evt_rst_i | input | 1 | Event-count reset: clears the trigger count and the receiver counts |
| rx_count_i | input | N_RX*CNT_W | Event count reported by each receiver; receiver k uses bits [k*CNT_W +: CNT_W] |
| rx_enable_i | input | N_RX | Per-receiver enable for the slowest-receiver choice |
| depth8_i | input | 1 | Buffer depth select: 0 gives 4 events, 1 gives 8 events |
| mask_en_i | input | 1 | Enables local trigger masking |
| buf_full_i | input | 1 | Event buffers are full |
| link_rdy_i | input | 1 | Data link is ready |
| busy_o | output | 1 | Busy to the trigger source (registered) |
| trig_mask_o | output | 1 | Current trigger is masked (combinational) |
| trig_cnt_o | output | CNT_W | Accepted trigger count |

## Verification
On every cycle, the assertions check the counter: it steps by one on an accepted trigger, holds on a masked one, and clears on an event-count reset. They also check that the tracked counts clear together, that busy stays low with no receiver enabled, and that busy is only ever high after a lag of at least four. Other behaviours can only be seen through the bench's scenarios, because they depend on the numeric relation between the count and the reported counts:
- which receiver is slowest;
- the exact busy threshold for each depth, and busy falling as a receiver catches up;
- the lag after the count wraps past 4095;
- the eight-event storage limit.

// File: rtl/meb_busy_pkg.sv
package meb_busy_pkg;
  // Depth select encoding on depth8_i
  typedef enum logic {
    DEPTH_FOUR  = 1'b0,
    DEPTH_EIGHT = 1'b1
  } depth_sel_e;

  localparam int unsigned DEPTH_SMALL   = 4;
  localparam int unsigned DEPTH_LARGE   = 8;
  localparam int unsigned STORAGE_LIMIT = 8;
endpackage

// File: rtl/meb_trig_counter.sv
module meb_trig_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             mask_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | (trig_i & ~mask_i);
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R1: an accepted trigger advances the count by one (with wrap)
  a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !mask_i && !clr_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  // R6: a masked trigger leaves the count alone
  a_r6_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && mask_i && !clr_i) |=> $stable(cnt_o));

  // R9: event-count reset clears the count
  a_r9_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/meb_rx_track.sv
module meb_rx_track #(
  parameter int unsigned N_RX  = 4,
  parameter int unsigned CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic [N_RX*CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0]      trig_cnt_i,
  output logic [N_RX*CNT_W-1:0] lag_o,
  output logic [N_RX-1:0]       zero_o
);
  for (genvar k = 0; k < N_RX; k++) begin : g_rx
    logic [CNT_W-1:0] seen_q;
    logic [CNT_W-1:0] seen_d;

    always_comb begin
      if (clr_i) seen_d = '0;
      else       seen_d = rx_count_i[k*CNT_W +: CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else        seen_q <= seen_d;
    end

    // modulo 2^CNT_W distance from this receiver to the trigger count
    assign lag_o[k*CNT_W +: CNT_W] = trig_cnt_i - seen_q;
    assign zero_o[k]               = (seen_q == '0);
  end

  // R9: all tracked counts are cleared in the same cycle
  a_r9_track_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (&zero_o));
endmodule

// File: rtl/meb_lag_select.sv
module meb_lag_select #(
  parameter int unsigned N_RX  = 4,
  parameter int unsigned CNT_W = 12
) (
  input  logic [N_RX*CNT_W-1:0] lag_i,
  input  logic [N_RX-1:0]       enable_i,
  output logic [CNT_W-1:0]      max_lag_o,
  output logic                  any_en_o
);
  always_comb begin
    max_lag_o = '0;
    any_en_o  = 1'b0;
    for (int k = 0; k < N_RX; k++) begin
      if (enable_i[k]) begin
        any_en_o = 1'b1;
        if (lag_i[k*CNT_W +: CNT_W] > max_lag_o)
          max_lag_o = lag_i[k*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/meb_busy_gen.sv
module meb_busy_gen #(
  parameter int unsigned N_RX  = 4,
  parameter int unsigned CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_i,
  input  logic                  evt_rst_i,
  input  logic [N_RX*CNT_W-1:0] rx_count_i,
  input  logic [N_RX-1:0]       rx_enable_i,
  input  logic                  depth8_i,
  input  logic                  mask_en_i,
  input  logic                  buf_full_i,
  input  logic                  link_rdy_i,
  output logic                  busy_o,
  output logic                  trig_mask_o,
  output logic [CNT_W-1:0]      trig_cnt_o
);
  import meb_busy_pkg::*;

  localparam logic [CNT_W-1:0] DEPTH_LO = CNT_W'(DEPTH_SMALL);
  localparam logic [CNT_W-1:0] DEPTH_HI = CNT_W'(DEPTH_LARGE);
  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(STORAGE_LIMIT);

  logic [CNT_W-1:0]      cnt;
  logic [N_RX*CNT_W-1:0] lags;
  logic [N_RX-1:0]       rx_zero;
  logic [CNT_W-1:0]      max_lag;
  logic                  any_en;
  logic [CNT_W-1:0]      depth;
  logic                  mask;
  logic                  busy_d;
  logic                  busy_q;

  meb_trig_counter #(.CNT_W(CNT_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .mask_i (mask),
    .clr_i  (evt_rst_i),
    .cnt_o  (cnt)
  );

  meb_rx_track #(.N_RX(N_RX), .CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (evt_rst_i),
    .rx_count_i (rx_count_i),
    .trig_cnt_i (cnt),
    .lag_o      (lags),
    .zero_o     (rx_zero)
  );

  meb_lag_select #(.N_RX(N_RX), .CNT_W(CNT_W)) u_select (
    .lag_i     (lags),
    .enable_i  (rx_enable_i),
    .max_lag_o (max_lag),
    .any_en_o  (any_en)
  );

  always_comb begin
    depth  = (depth_sel_e'(depth8_i) == DEPTH_EIGHT) ? DEPTH_HI : DEPTH_LO;
    mask   = mask_en_i & (buf_full_i | ~link_rdy_i | (any_en & (max_lag >= LIMIT)));
    busy_d = any_en & (max_lag >= depth);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o      = busy_q;
  assign trig_mask_o = mask;
  assign trig_cnt_o  = cnt;

  // R5: no enabled receiver means no busy
  a_r5_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_enable_i == '0) |=> !busy_o);

  // R3: busy is only raised after a lag of at least the smaller depth
  a_r3_busy_needs_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(max_lag) >= DEPTH_LO));

  // R8: masking disabled never masks
  a_r8_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en_i |-> !trig_mask_o);
endmodule

// File: tb/meb_busy_gen_bench.sv
module meb_busy_gen_bench;
  localparam int N = 4;
  localparam int W = 12;

  logic           clk;
  logic           rst_n;
  logic           trig, evt_rst, depth8, mask_en, buf_full, link_rdy;
  logic [N*W-1:0] rx_count;
  logic [N-1:0]   rx_en;
  logic           busy, tmask;
  logic [W-1:0]   tcnt;

  meb_busy_gen #(.N_RX(N), .CNT_W(W)) u_meb_busy_gen (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .evt_rst_i(evt_rst),
    .rx_count_i(rx_count), .rx_enable_i(rx_en), .depth8_i(depth8),
    .mask_en_i(mask_en), .buf_full_i(buf_full), .link_rdy_i(link_rdy),
    .busy_o(busy), .trig_mask_o(tmask), .trig_cnt_o(tcnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W-1:0]   m_cnt;
  logic [N*W-1:0] m_rx;
  logic           m_busy;

  function automatic logic [W-1:0] f_maxlag(input logic [W-1:0] c,
                                            input logic [N*W-1:0] r,
                                            input logic [N-1:0] en);
    logic [W-1:0] best = '0;
    for (int k = 0; k < N; k++) begin
      logic [W-1:0] l = c - r[k*W +: W];
      if (en[k] && l > best) best = l;
    end
    return best;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check mask before the edge, check state after it
  task automatic step(input string tag, input logic t, input logic [N*W-1:0] rx,
                      input logic [N-1:0] en, input logic d8, input logic men,
                      input logic full, input logic rdy, input logic er);
    logic [W-1:0] ml;
    logic         any, exp_mask, nb;
    trig = t; rx_count = rx; rx_en = en; depth8 = d8; mask_en = men;
    buf_full = full; link_rdy = rdy; evt_rst = er;
    #1;
    ml  = f_maxlag(m_cnt, m_rx, en);
    any = |en;
    exp_mask = men & (full | ~rdy | (any & (ml >= 8)));
    chk({tag, " mask R6/R7/R8"}, tmask, exp_mask);
    nb = any & (ml >= (d8 ? 12'd8 : 12'd4));
    @(posedge clk);
    m_busy = nb;
    if (er) m_cnt = '0;
    else if (t && !exp_mask) m_cnt = m_cnt + 1'b1;
    m_rx = er ? '0 : rx;
    @(negedge clk);
    chk({tag, " count R1/R9"}, tcnt, m_cnt);
    chk({tag, " busy R3/R4/R5"}, busy, m_busy);
  endtask

  function automatic logic [N*W-1:0] all_rx(input logic [W-1:0] v);
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = v;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] r;
    void'($urandom(32'd20240611));
    rst_n = 0; trig = 0; evt_rst = 0; depth8 = 0; mask_en = 0;
    buf_full = 0; link_rdy = 1; rx_count = '0; rx_en = '0;
    m_cnt = '0; m_rx = '0; m_busy = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset count", tcnt, 0);
    chk("R10 reset busy", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 first edge busy", busy, 0);

    // R3/R4 depth 4 with receiver 0 only
    for (int i = 0; i < 5; i++) step("R3 d4", 1, '0, 4'b0001, 0, 0, 0, 1, 0);
    step("R3 d4 hold", 0, '0, 4'b0001, 0, 0, 0, 1, 0);
    chk("R3 busy at lag 5 depth 4", busy, 1);
    step("R4 catch up", 0, all_rx(12'd3), 4'b0001, 0, 0, 0, 1, 0);
    step("R4 catch up", 0, all_rx(12'd3), 4'b0001, 0, 0, 0, 1, 0);
    chk("R4 busy low at lag 2", busy, 0);

    // R3 depth 8 threshold and R2 slowest receiver
    r = all_rx(12'd5); r[2*W +: W] = 12'd0;   // receiver 2 is slowest (lag 5)
    step("R2 slowest", 0, r, 4'b1111, 1, 0, 0, 1, 0);
    step("R2 slowest", 0, r, 4'b1111, 1, 0, 0, 1, 0);
    chk("R3 lag 5 below depth 8", busy, 0);
    for (int i = 0; i < 3; i++) step("R3 d8", 1, r, 4'b1111, 1, 0, 0, 1, 0);
    step("R3 d8", 0, r, 4'b1111, 1, 0, 0, 1, 0);
    chk("R2 busy driven by slowest at lag 8", busy, 1);
    step("R5 exclude slow", 0, r, 4'b1011, 1, 0, 0, 1, 0);
    step("R5 exclude slow", 0, r, 4'b1011, 1, 0, 0, 1, 0);
    chk("R5 disabled slow receiver ignored", busy, 0);
    step("R5 none enabled", 0, '0, 4'b0000, 0, 0, 0, 1, 0);
    chk("R5 no receiver enabled", busy, 0);

    // R6 / R7 / R8 masking
    step("R6 full", 1, '0, 4'b0001, 0, 1, 1, 1, 0);
    step("R6 link", 1, '0, 4'b0001, 0, 1, 0, 0, 0);
    step("R7 limit", 1, '0, 4'b0001, 1, 1, 0, 1, 0);
    chk("R7 count held at limit", tcnt, 8);
    step("R8 off", 1, '0, 4'b0001, 1, 0, 1, 0, 0);
    chk("R8 counted with mask off", tcnt, 9);

    // R9 reset wins over trigger
    step("R9 clear", 1, all_rx(12'd7), 4'b1111, 0, 0, 0, 1, 1);
    chk("R9 count zero", tcnt, 0);
    step("R9 after", 0, all_rx(12'd0), 4'b1111, 0, 0, 0, 1, 0);
    chk("R9 tracked counts cleared", busy, 0);

    // R1/R2 wraparound
    for (int i = 0; i < 4100; i++)
      step("R1 wrap", 1, all_rx(m_cnt - 12'd2), 4'b1111, 0, 0, 0, 1, 0);
    chk("R1 wrapped count", tcnt, 12'd4);
    step("R2 wrap lag", 0, all_rx(12'd4094), 4'b1111, 0, 0, 0, 1, 0);
    step("R2 wrap lag", 0, all_rx(12'd4094), 4'b1111, 0, 0, 0, 1, 0);
    chk("R2 lag 6 across wrap", busy, 1);

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [N*W-1:0] rr;
      for (int k = 0; k < N; k++) rr[k*W +: W] = m_cnt - W'($urandom % 12);
      step("rand", 1'($urandom), rr, 4'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 4) == 0, ($urandom % 4) != 0, ($urandom % 64) == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule